// File: doc/BRIEF.md
# Multicycle Processor Core with Shared Memory Port

This block is a small 32-bit processor core that executes a subset of integer instructions: word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and unconditional jump. It splits every instruction into steps of one clock each. A short step means a short clock period, and simple instructions finish in fewer clocks than loads.

The core has one memory port that it uses for both instruction fetch and data access, and one ALU. The ALU also advances the program counter and forms branch targets. Holding registers sit after the big units: the instruction register, the memory data register, the two operand registers and the ALU result register. Only the instruction register, the program counter, the register file and memory have write enables. The holding registers capture on every edge. A state-machine sequencer drives all selects and enables.

The memory is outside the core. Its read data must follow the address combinationally, and writes land on the rising clock edge while the write strobe is high. The `step` and `done` outputs let an observer count the clocks that each instruction takes.

Top module: `mc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and puts the sequencer in the fetch step (step code 0). No memory write is requested during reset.
- R2: During fetch (step 0), the memory address is the program counter. The word read is captured as the instruction. The program counter is incremented by 4 at the end of fetch. The next step is always decode (step 1), and the instruction is held unchanged until the next fetch.
- R3: Encodings: opcode is bits 31:26 (0x00 register form, 0x23 load, 0x2B store, 0x04 branch-if-equal, 0x02 jump); source registers are in bits 25:21 and 20:16; the register-form destination is in bits 15:11; the function code is in bits 5:0. Counted from fetch, a register-form op takes 4 clocks, a load 5, a store 4, a branch 3 and a jump 3. `done` is high in the final clock only, and the following clock is a fetch.
- R4: Register-form function codes 0x20, 0x22, 0x24, 0x25 and 0x2A write the sum, difference, bitwise and, bitwise or, and the signed less-than flag (1 or 0) of the two source registers into the destination.
- R5: A load reads the word at the first source register plus the sign-extended 16-bit offset and writes it into the register named in bits 20:16.
- R6: A store writes the register named in bits 20:16 to the first source register plus the sign-extended offset. The write strobe is high for exactly one clock, and no other instruction raises it.
- R7: Branch-if-equal sets the program counter to (address of branch + 4) + (sign-extended offset × 4) when both registers are equal. Otherwise it leaves the counter at address + 4.
- R8: A jump sets the program counter to the upper 4 bits of (address + 4), followed by instruction bits 25:0, followed by two zero bits.
- R9: Register 0 always reads as zero. A write to it has no effect.
- R10: An instruction with any other opcode ends after decode (2 clocks) and changes no register, memory or branch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address of the single memory port |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Combinational read data for mem_addr |
| pc | output | 32 | Current program counter |
| step | output | 4 | Sequencer step code (0 fetch, 1 decode, 2 execute, 3 result write, 4 address, 5 load read, 6 load write, 7 store, 8 branch, 9 jump) |
| done | output | 1 | High in the last clock of an instruction |

## Verification
The bench runs a fixed program that touches every instruction kind, a taken and a not-taken branch, a jump over code, a write to register 0, a negative compare and an unknown opcode. A scoreboard holds three expected streams: the program-counter value at each fetch clock, the clock count from each fetch to its `done`, and the address and data of each store. The fetch counter value is due in the same clock that `step` reads 0. The clock count is due in the clock where `done` is high. Store results appear on the memory port in the fourth clock of a store, after two earlier loads and R-form results have passed through the holding registers. All outputs are sampled on the falling edge, inside the very clock that the requirement names. A store that arrives with no expected entry fails at once, so skipped code and register-0 writes are observed at the ports.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN      = 32;
    localparam int OP_HI     = 31;
    localparam int FN_W      = 6;
    localparam int IMM_W     = 16;
    localparam int JT_W      = 26;
    localparam int RS_LO     = 21;
    localparam int RT_LO     = 16;
    localparam int RD_LO     = 11;
    localparam int STEP_W    = 4;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_JUMP  = 6'h02;

    localparam logic [5:0] FC_ADD = 6'h20;
    localparam logic [5:0] FC_SUB = 6'h22;
    localparam logic [5:0] FC_AND = 6'h24;
    localparam logic [5:0] FC_OR  = 6'h25;
    localparam logic [5:0] FC_SLT = 6'h2A;

    typedef enum logic [STEP_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_EXEC   = 4'd2,
        ST_RWB    = 4'd3,
        ST_ADDR   = 4'd4,
        ST_LDRD   = 4'd5,
        ST_LDWB   = 4'd6,
        ST_STWR   = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9
    } step_e;

    typedef enum logic [2:0] {
        FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT
    } alu_fn_e;

    typedef enum logic { SRC_A_PC, SRC_A_REG } src_a_e;

    typedef enum logic [1:0] {
        SRC_B_REG, SRC_B_FOUR, SRC_B_IMM, SRC_B_BOFS
    } src_b_e;

    typedef enum logic [1:0] { PC_FROM_ALU, PC_FROM_OUT, PC_FROM_JMP } pc_src_e;

    typedef struct packed {
        logic    ir_we;
        logic    pc_we;
        logic    br_cond;
        logic    addr_out;
        logic    mem_we;
        logic    reg_we;
        logic    dst_rd;
        logic    wb_mem;
        src_a_e  src_a;
        src_b_e  src_b;
        alu_fn_e fn;
        pc_src_e pc_src;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        ir_we: 1'b0, pc_we: 1'b0, br_cond: 1'b0, addr_out: 1'b0,
        mem_we: 1'b0, reg_we: 1'b0, dst_rd: 1'b0, wb_mem: 1'b0,
        src_a: SRC_A_PC, src_b: SRC_B_FOUR, fn: FN_ADD, pc_src: PC_FROM_ALU
    };

    function automatic alu_fn_e func_to_fn(input logic [FN_W-1:0] fc);
        case (fc)
            FC_SUB:  return FN_SUB;
            FC_AND:  return FN_AND;
            FC_OR:   return FN_OR;
            FC_SLT:  return FN_SLT;
            default: return FN_ADD;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DW    = 32,
    parameter int NREGS = 32,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [RAW-1:0] ra1,
    input  logic [RAW-1:0] ra2,
    output logic [DW-1:0]  rd1,
    output logic [DW-1:0]  rd2,
    input  logic           we,
    input  logic [RAW-1:0] wa,
    input  logic [DW-1:0]  wd
);
    logic [DW-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_fn_e       fn,
    output logic [DW-1:0] y,
    output logic          zero
);
    logic lt;
    assign lt = $signed(a) < $signed(b);

    always_comb begin
        case (fn)
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_SLT:  y = {{(DW-1){1'b0}}, lt};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [5:0]      opcode,
    input  logic [FN_W-1:0] func,
    output step_e           state,
    output ctrl_t           ctrl,
    output logic            done
);
    step_e nxt;
    logic  known_op;

    assign known_op = (opcode == OPC_REG)   || (opcode == OPC_LOAD) ||
                      (opcode == OPC_STORE) || (opcode == OPC_BEQ)  ||
                      (opcode == OPC_JUMP);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        nxt = ST_FETCH;
        case (state)
            ST_FETCH: nxt = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OPC_REG:              nxt = ST_EXEC;
                    OPC_LOAD, OPC_STORE:  nxt = ST_ADDR;
                    OPC_BEQ:              nxt = ST_BRANCH;
                    OPC_JUMP:             nxt = ST_JUMP;
                    default:              nxt = ST_FETCH;
                endcase
            end
            ST_EXEC:  nxt = ST_RWB;
            ST_ADDR:  nxt = (opcode == OPC_LOAD) ? ST_LDRD : ST_STWR;
            ST_LDRD:  nxt = ST_LDWB;
            default:  nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        ctrl = CTRL_IDLE;
        done = 1'b0;
        case (state)
            ST_FETCH: begin
                ctrl.ir_we = 1'b1;
                ctrl.pc_we = 1'b1;
            end
            ST_DECODE: begin
                ctrl.src_b = SRC_B_BOFS;
                done       = !known_op;
            end
            ST_EXEC: begin
                ctrl.src_a = SRC_A_REG;
                ctrl.src_b = SRC_B_REG;
                ctrl.fn    = func_to_fn(func);
            end
            ST_RWB: begin
                ctrl.reg_we = 1'b1;
                ctrl.dst_rd = 1'b1;
                done        = 1'b1;
            end
            ST_ADDR: begin
                ctrl.src_a = SRC_A_REG;
                ctrl.src_b = SRC_B_IMM;
            end
            ST_LDRD: ctrl.addr_out = 1'b1;
            ST_LDWB: begin
                ctrl.reg_we = 1'b1;
                ctrl.wb_mem = 1'b1;
                done        = 1'b1;
            end
            ST_STWR: begin
                ctrl.addr_out = 1'b1;
                ctrl.mem_we   = 1'b1;
                done          = 1'b1;
            end
            ST_BRANCH: begin
                ctrl.src_a   = SRC_A_REG;
                ctrl.src_b   = SRC_B_REG;
                ctrl.fn      = FN_SUB;
                ctrl.br_cond = 1'b1;
                ctrl.pc_src  = PC_FROM_OUT;
                done         = 1'b1;
            end
            ST_JUMP: begin
                ctrl.pc_we  = 1'b1;
                ctrl.pc_src = PC_FROM_JMP;
                done        = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int DW   = XLEN,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_we,
    input  logic [DW-1:0]     mem_rdata,
    output logic [DW-1:0]     pc,
    output logic [STEP_W-1:0] step,
    output logic              done
);
    logic [DW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, out_q;
    logic [DW-1:0] rd1, rd2, alu_a, alu_b, alu_y, pc_nxt, imm_x, wb_data;
    logic [RAW-1:0] wa;
    logic          alu_zero, pc_load;
    step_e         state;
    ctrl_t         c;

    mc_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir_q[OP_HI -: 6]),
        .func   (ir_q[FN_W-1:0]),
        .state  (state),
        .ctrl   (c),
        .done   (done)
    );

    assign wa      = c.dst_rd ? ir_q[RD_LO +: RAW] : ir_q[RT_LO +: RAW];
    assign wb_data = c.wb_mem ? mdr_q : out_q;

    mc_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ir_q[RS_LO +: RAW]),
        .ra2 (ir_q[RT_LO +: RAW]),
        .rd1 (rd1),
        .rd2 (rd2),
        .we  (c.reg_we),
        .wa  (wa),
        .wd  (wb_data)
    );

    assign imm_x = sext_imm(ir_q[IMM_W-1:0]);
    assign alu_a = (c.src_a == SRC_A_PC) ? pc_q : a_q;

    always_comb begin
        case (c.src_b)
            SRC_B_REG:  alu_b = b_q;
            SRC_B_FOUR: alu_b = DW'(4);
            SRC_B_IMM:  alu_b = imm_x;
            default:    alu_b = imm_x << 2;
        endcase
    end

    mc_alu #(.DW(DW)) u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .fn   (c.fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        case (c.pc_src)
            PC_FROM_OUT: pc_nxt = out_q;
            PC_FROM_JMP: pc_nxt = {pc_q[DW-1 -: 4], ir_q[JT_W-1:0], 2'b00};
            default:     pc_nxt = alu_y;
        endcase
    end

    assign pc_load = c.pc_we || (c.br_cond && alu_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            if (pc_load) pc_q <= pc_nxt;
            if (c.ir_we) ir_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mdr_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            out_q <= '0;
        end else begin
            mdr_q <= mem_rdata;
            a_q   <= rd1;
            b_q   <= rd2;
            out_q <= alu_y;
        end
    end

    assign mem_addr  = c.addr_out ? out_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_we    = c.mem_we;
    assign pc        = pc_q;
    assign step      = state;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  step,
    input logic [31:0] pc,
    input logic [31:0] ir,
    input logic        mem_we,
    input logic        done
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == 32'd0 && step == 4'd0 && !mem_we));

    // R2
    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        (step == 4'd0) |=> (step == 4'd1));

    // R2
    a_r2_pc_advance: assert property (@(posedge clk) disable iff (rst)
        (step == 4'd0) |=> (pc == $past(pc) + 32'd4));

    // R2
    a_r2_ir_held: assert property (@(posedge clk) disable iff (rst)
        (step != 4'd0) |=> $stable(ir));

    // R3
    a_r3_done_to_fetch: assert property (@(posedge clk) disable iff (rst)
        done |=> (step == 4'd0));

    // R6
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R7
    a_r7_pc_quiet: assert property (@(posedge clk) disable iff (rst)
        (step != 4'd0 && step != 4'd8 && step != 4'd9) |=> $stable(pc));

    // R8
    a_r8_jump_region: assert property (@(posedge clk) disable iff (rst)
        (step == 4'd9) |=> (pc[31:28] == $past(pc[31:28])));
endmodule

bind mc_core mc_core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .pc     (pc),
    .ir     (ir_q),
    .mem_we (mem_we),
    .done   (done)
);

// File: tb/sim_mc_core.sv
module sim_mc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, pc;
    logic        mem_we, done;
    logic [3:0]  step;

    always #5 clk = ~clk;

    mc_core u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .step      (step),
        .done      (done)
    );

    logic [31:0] mem [256];
    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

    int total = 0;
    int bad   = 0;
    bit running = 1'b0;
    int cyc_cnt = 0;

    logic [31:0] q_pc[$];
    int          q_cyc[$];
    string       q_itag[$];
    logic [31:0] q_sa[$];
    logic [31:0] q_sd[$];
    string       q_stag[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic expect_instr(input logic [31:0] a, input int cycles, input string tag);
        q_pc.push_back(a);
        q_cyc.push_back(cycles);
        q_itag.push_back(tag);
    endtask

    task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string tag);
        q_sa.push_back(a);
        q_sd.push_back(d);
        q_stag.push_back(tag);
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fc);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fc};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // Scoreboard monitor, sampling between edges
    always @(negedge clk) begin
        if (running && !rst) begin
            string t;
            cyc_cnt++;
            if (step == 4'd0) begin
                if (q_pc.size() == 0) check(1'b0, "R2 unexpected fetch", pc, 32'hFFFFFFFF);
                else begin
                    t = q_itag[0];
                    check(pc == q_pc[0], {t, " R2 fetch address"}, pc, q_pc[0]);
                    check(mem_addr == pc, "R2 fetch uses pc as address", mem_addr, pc);
                    void'(q_pc.pop_front());
                end
            end
            if (mem_we) begin
                if (q_sa.size() == 0) check(1'b0, "R6 unexpected store", mem_addr, 32'hFFFFFFFF);
                else begin
                    t = q_stag[0];
                    check(mem_addr == q_sa[0], {t, " store address"}, mem_addr, q_sa[0]);
                    check(mem_wdata == q_sd[0], {t, " store data"}, mem_wdata, q_sd[0]);
                    void'(q_sa.pop_front());
                    void'(q_sd.pop_front());
                    void'(q_stag.pop_front());
                end
            end
            if (done) begin
                if (q_cyc.size() == 0) check(1'b0, "R3 unexpected done", 32'(cyc_cnt), 32'd0);
                else begin
                    t = q_itag[0];
                    check(cyc_cnt == q_cyc[0], {t, " R3 clocks per instruction"}, 32'(cyc_cnt), 32'(q_cyc[0]));
                    void'(q_cyc.pop_front());
                    void'(q_itag.pop_front());
                end
                cyc_cnt = 0;
            end
        end
    end

    initial begin
        int wd;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[64] = 32'd7;
        mem[65] = 32'd5;
        mem[0]  = enc_i(6'h23, 0, 1, 16'h0100);
        mem[1]  = enc_i(6'h23, 0, 2, 16'h0104);
        mem[2]  = enc_r(1, 2, 3, 6'h20);
        mem[3]  = enc_r(1, 2, 4, 6'h22);
        mem[4]  = enc_r(1, 2, 5, 6'h24);
        mem[5]  = enc_r(1, 2, 6, 6'h25);
        mem[6]  = enc_r(2, 1, 7, 6'h2A);
        mem[7]  = enc_r(1, 2, 8, 6'h2A);
        mem[8]  = enc_i(6'h2B, 0, 3, 16'h0200);
        mem[9]  = enc_i(6'h2B, 0, 4, 16'h0204);
        mem[10] = enc_i(6'h2B, 0, 5, 16'h0208);
        mem[11] = enc_i(6'h2B, 0, 6, 16'h020C);
        mem[12] = enc_i(6'h2B, 0, 7, 16'h0210);
        mem[13] = enc_i(6'h2B, 0, 8, 16'h0214);
        mem[14] = enc_i(6'h04, 1, 2, 16'd5);
        mem[15] = enc_i(6'h04, 5, 2, 16'd2);
        mem[16] = enc_i(6'h2B, 0, 1, 16'h0218);
        mem[17] = enc_i(6'h2B, 0, 1, 16'h021C);
        mem[18] = enc_r(1, 1, 0, 6'h20);
        mem[19] = enc_i(6'h2B, 0, 0, 16'h0220);
        mem[20] = {6'h02, 26'd24};
        mem[21] = enc_i(6'h2B, 0, 1, 16'h0224);
        mem[24] = enc_i(6'h2B, 0, 2, 16'h0228);
        mem[25] = enc_r(2, 1, 9, 6'h22);
        mem[26] = enc_r(9, 0, 10, 6'h2A);
        mem[27] = enc_i(6'h2B, 0, 10, 16'h022C);
        mem[28] = 32'hFC00_0000;
        mem[29] = enc_i(6'h04, 0, 0, 16'hFFFF);

        expect_instr(32'd0,   5, "R5 load r1");
        expect_instr(32'd4,   5, "R5 load r2");
        expect_instr(32'd8,   4, "R4 add");
        expect_instr(32'd12,  4, "R4 sub");
        expect_instr(32'd16,  4, "R4 and");
        expect_instr(32'd20,  4, "R4 or");
        expect_instr(32'd24,  4, "R4 slt true");
        expect_instr(32'd28,  4, "R4 slt false");
        for (int i = 0; i < 6; i++) expect_instr(32'd32 + 32'(4*i), 4, "R6 store");
        expect_instr(32'd56,  3, "R7 branch not taken");
        expect_instr(32'd60,  3, "R7 branch taken");
        expect_instr(32'd72,  4, "R9 write r0");
        expect_instr(32'd76,  4, "R9 store r0");
        expect_instr(32'd80,  3, "R8 jump");
        expect_instr(32'd96,  4, "R8 jump landing store");
        expect_instr(32'd100, 4, "R4 negative sub");
        expect_instr(32'd104, 4, "R4 signed slt");
        expect_instr(32'd108, 4, "R6 store flag");
        expect_instr(32'd112, 2, "R10 unknown opcode");
        for (int i = 0; i < 3; i++) expect_instr(32'd116, 3, "R7 backward branch");

        expect_store(32'h200, 32'd12, "R4 R6 add result");
        expect_store(32'h204, 32'd2,  "R4 R6 sub result");
        expect_store(32'h208, 32'd5,  "R4 R6 and result");
        expect_store(32'h20C, 32'd7,  "R4 R6 or result");
        expect_store(32'h210, 32'd1,  "R4 R6 slt true");
        expect_store(32'h214, 32'd0,  "R4 R6 slt false");
        expect_store(32'h220, 32'd0,  "R9 r0 stays zero");
        expect_store(32'h228, 32'd5,  "R8 R5 after jump");
        expect_store(32'h22C, 32'd1,  "R4 signed compare");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc == 32'd0, "R1 reset pc", pc, 32'd0);
        check(step == 4'd0, "R1 reset step", 32'(step), 32'd0);
        check(!mem_we, "R1 no write in reset", 32'(mem_we), 32'd0);
        check(!done, "R1 no done in reset", 32'(done), 32'd0);

        @(posedge clk);
        #1 rst = 1'b0;
        running = 1'b1;

        wd = 0;
        while (q_cyc.size() != 0 && wd < 5000) begin
            @(negedge clk);
            wd++;
        end
        running = 1'b0;
        check(wd < 5000, "watchdog expired", 32'(wd), 32'd5000);
        check(q_sa.size() == 0, "R6 missing stores", 32'(q_sa.size()), 32'd0);
        check(mem[134] == 32'd0, "R7 skipped store not written", mem[134], 32'd0);
        check(mem[135] == 32'd0, "R7 skipped store not written", mem[135], 32'd0);
        check(mem[137] == 32'd0, "R8 jumped-over store not written", mem[137], 32'd0);
        check(mem[64] == 32'd7, "R10 data untouched", mem[64], 32'd7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule